// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a serial slave for a two-wire bus, one clock line and one open-drain data line. It gives an external host access to a bank of 8-bit registers held elsewhere in the chip. Both bus lines pass through a two-flop synchroniser. Clock edges, start conditions and stop conditions are found by sampling the synchronised lines on the system clock, which must run at least eight times faster than the bus clock.

Each transaction carries exactly one internal-address byte and one data byte. A write is:

- start, then the device address with the direction bit at 0, then the slave's acknowledge;
- the register address, then an acknowledge;
- one data byte, then an acknowledge;
- stop.

A read begins with the same addressed phase and the register-address byte. The master then sends a repeated start and the device address with the direction bit at 1. The slave acknowledges and returns one byte. The master closes with a not-acknowledge and a stop. The register address taken during the write-direction phase is kept across the repeated start.

The controller is one state machine with ten states:

- ST_IDLE waits for a start.
- ST_DEV_ADDR shifts in the address byte. At the end of the byte it goes to ST_DEV_ACK on a match, or to ST_WAIT on a miss.
- ST_DEV_ACK pulls the line low for one bit. It then goes to ST_REG_ADDR (write direction) or ST_RD_DATA (read direction).
- ST_REG_ADDR shifts in the register address, then goes to ST_REG_ACK.
- ST_REG_ACK acknowledges, then goes to ST_WR_DATA.
- ST_WR_DATA shifts in the data byte, then goes to ST_WR_ACK.
- ST_WR_ACK acknowledges. As it ends it issues the write strobe and goes to ST_WAIT.
- ST_RD_DATA drives the eight read bits, then goes to ST_RD_ACK.
- ST_RD_ACK releases the line for the master's answer bit, then goes to ST_WAIT.
- ST_WAIT ignores the bus.

From any state, a start goes to ST_DEV_ADDR and a stop goes to ST_IDLE.

Top module: `twi_reg_slave`

## Requirements
- R1: After reset, sda_oe, reg_wr_en and reg_rd_en are all 0.
- R2: The address byte is sent MSB first. Its upper 7 bits are the device address and bit 0 is the direction (0 = write, 1 = read). In a write transaction to the matching address (DEV_ADDR, default 7'h2A), the slave pulls the data line low during all three acknowledge bits. After the ninth clock of the data byte ends, it gives exactly one reg_wr_en pulse carrying the register-address byte and the data byte.
- R3: When the upper 7 bits of the address byte differ from DEV_ADDR, the slave gives no acknowledge and never drives the line until the next start. It issues no write strobe and no read request for that transaction.
- R4: In a read transaction, the slave raises reg_rd_en once with reg_rd_addr equal to the register address latched before the repeated start. It samples reg_rd_data, which must stay valid from the cycle after the request until the acknowledge bit ends. It returns the byte MSB first: a 0 bit pulls the line low, and a 1 bit releases it.
- R5: After the eighth read bit, the slave releases the data line during the master's answer bit and keeps it released until the next start or stop.
- R6: sda_oe changes only while the bus clock is low.
- R7: A start condition in any state, including in the middle of a byte, restarts address reception from bit 0.
- R8: A stop returns the slave to idle and discards the latched register address. A read-direction address byte arriving after a stop, with no register-address phase since, is not acknowledged and causes no read request.
- R9: reg_wr_en is never high for two cycles in a row, and is never high together with reg_rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 8 | Register address for the write |
| reg_wr_data | output | 8 | Data byte for the write |
| reg_rd_en | output | 1 | One-cycle register read request |
| reg_rd_addr | output | 8 | Register address for the read |
| reg_rd_data | input | 8 | Read data returned by the register bank |

## Verification
On every cycle the assertions check four things:

- the data line's drive changes only while the clock is low;
- a start always leads to address reception and a stop always leads to idle;
- the line is released in idle, in the ignore state and during the master's answer bit;
- the write strobe lasts a single cycle and never coincides with a read request.

Only the bench's scenarios can show the rest. These are the sweep of all 128 device addresses, where only the configured one is acknowledged and produces a strobe, and the data values written and then read back through repeated starts. They also cover the restart of a byte cut off by a start, and the refusal of a read after a stop.

// File: rtl/twi_pkg.sv
package twi_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W) + 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV_ADDR,
        ST_DEV_ACK,
        ST_REG_ADDR,
        ST_REG_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_WAIT
    } twi_state_t;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/twi_cond_det.sv
module twi_cond_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign scl_rise  = scl && !scl_q;
    assign scl_fall  = !scl && scl_q;
    assign start_det = scl && scl_q && sda_q && !sda;
    assign stop_det  = scl && scl_q && !sda_q && sda;
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
    import twi_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              reg_wr_en,
    output logic [BYTE_W-1:0] reg_wr_addr,
    output logic [BYTE_W-1:0] reg_wr_data,
    output logic              reg_rd_en,
    output logic [BYTE_W-1:0] reg_rd_addr,
    input  logic [BYTE_W-1:0] reg_rd_data
);
    localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

    logic [1:0] line_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_det, stop_det;

    twi_state_t        state, state_d;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg, reg_addr_q;
    logic              addr_ok, rd_dir, rd_req_q;
    logic              byte_end, addr_hit, receiving;

    twi_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(line_s)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    twi_cond_det u_cond (
        .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign byte_end  = scl_fall && (cnt == LAST_RX);
    assign addr_hit  = (shreg[BYTE_W-1:1] == DEV_ADDR) && (!shreg[0] || addr_ok);
    assign receiving = (state == ST_DEV_ADDR) || (state == ST_REG_ADDR) ||
                       (state == ST_WR_DATA);

    // next-state logic
    always_comb begin
        state_d = state;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_DEV_ADDR;
        end else begin
            unique case (state)
                ST_IDLE, ST_WAIT: state_d = state;
                ST_DEV_ADDR: if (byte_end) state_d = addr_hit ? ST_DEV_ACK : ST_WAIT;
                ST_DEV_ACK:  if (scl_fall) state_d = rd_dir ? ST_RD_DATA : ST_REG_ADDR;
                ST_REG_ADDR: if (byte_end) state_d = ST_REG_ACK;
                ST_REG_ACK:  if (scl_fall) state_d = ST_WR_DATA;
                ST_WR_DATA:  if (byte_end) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_d = ST_WAIT;
                ST_RD_DATA:  if (scl_fall && cnt == LAST_TX) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_rise) state_d = ST_WAIT;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            shreg      <= '0;
            reg_addr_q <= '0;
            addr_ok    <= 1'b0;
            rd_dir     <= 1'b0;
            rd_req_q   <= 1'b0;
        end else begin
            state    <= state_d;
            rd_req_q <= 1'b0;
            if (start_det || stop_det) begin
                cnt <= '0;
                if (stop_det) addr_ok <= 1'b0;
            end else begin
                if (receiving && scl_rise && cnt < LAST_RX) begin
                    shreg <= {shreg[BYTE_W-2:0], sda_s};
                    cnt   <= cnt + 1'b1;
                end
                if (receiving && byte_end) cnt <= '0;
                if (state == ST_DEV_ADDR && byte_end) begin
                    rd_dir   <= shreg[0];
                    rd_req_q <= addr_hit && shreg[0];
                end
                if (state == ST_REG_ADDR && byte_end) reg_addr_q <= shreg;
                if (state == ST_REG_ACK && scl_fall) addr_ok <= 1'b1;
                if (state == ST_DEV_ACK && scl_fall && rd_dir) begin
                    shreg <= reg_rd_data;
                    cnt   <= '0;
                end
                if (state == ST_RD_DATA && scl_fall && cnt < LAST_TX) begin
                    shreg <= {shreg[BYTE_W-2:0], 1'b1};
                    cnt   <= cnt + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_REG_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_DATA:                        sda_oe = !shreg[BYTE_W-1];
            default:                           sda_oe = 1'b0;
        endcase
        reg_wr_en   = (state == ST_WR_ACK) && scl_fall && !start_det && !stop_det;
        reg_wr_addr = reg_addr_q;
        reg_wr_data = shreg;
        reg_rd_en   = rd_req_q;
        reg_rd_addr = reg_addr_q;
    end
endmodule

// File: rtl/twi_reg_slave_chk.sv
module twi_reg_slave_chk
    import twi_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_oe,
    input logic       reg_wr_en,
    input logic       reg_rd_en,
    input logic       start_det,
    input logic       stop_det,
    input twi_state_t state
);
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);                                        // R6
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);                                           // R9
    AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));                                          // R9
    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> state == ST_DEV_ADDR);                                 // R7
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> state == ST_IDLE);                                      // R8
    AST_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_WAIT || state == ST_RD_ACK) |-> !sda_oe); // R5
endmodule

bind twi_reg_slave twi_reg_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .start_det(start_det), .stop_det(stop_det), .state(state)
);

// File: tb/twi_reg_slave_bench.sv
`timescale 1ns/1ps
module twi_reg_slave_bench;
    localparam logic [6:0] DEV = 7'h2A;
    localparam int Q = 6;

    logic clk = 0, rst_n = 0, scl = 1, m_sda = 1;
    logic sda_oe, reg_wr_en, reg_rd_en;
    logic [7:0] reg_wr_addr, reg_wr_data, reg_rd_addr, reg_rd_data;
    logic sda_line;
    logic [7:0] mem [256];
    int n_checks = 0, n_fail = 0, wr_cnt = 0, rd_cnt = 0;
    int width_err = 0, excl_err = 0, oe_err = 0;
    logic [7:0] wr_a, wr_d, rd_a;
    logic prev_wr = 0, prev_oe = 0, done = 0;

    always #10 clk = ~clk;
    assign sda_line    = m_sda & ~sda_oe;
    assign reg_rd_data = mem[reg_rd_addr];

    twi_reg_slave #(.DEV_ADDR(DEV)) u_twi_reg_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr_en) begin
                wr_cnt++; wr_a = reg_wr_addr; wr_d = reg_wr_data;
                mem[reg_wr_addr] = reg_wr_data;
                if (prev_wr) width_err++;
                if (reg_rd_en) excl_err++;
            end
            if (reg_rd_en) begin rd_cnt++; rd_a = reg_rd_addr; end
            if (sda_oe != prev_oe && scl) oe_err++;
        end
        prev_wr = reg_wr_en;
        prev_oe = sda_oe;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1; scl = 1; wait_q(Q);
        m_sda = 0; wait_q(Q);
        scl = 0; wait_q(Q);
    endtask

    task automatic bus_stop();
        m_sda = 0; wait_q(Q);
        scl = 1; wait_q(Q);
        m_sda = 1; wait_q(Q);
    endtask

    task automatic xfer_bit(input logic b, output logic r);
        m_sda = b; wait_q(Q);
        scl = 1; wait_q(Q/2);
        r = sda_line; wait_q(Q/2);
        scl = 0; wait_q(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) xfer_bit(v[i], r);
        xfer_bit(1'b1, r);
        acked = !r;
    endtask

    task automatic write_txn(input logic [6:0] dev, input logic [7:0] ra, input logic [7:0] d,
                             output logic [2:0] acks);
        bus_start();
        send_byte({dev, 1'b0}, acks[0]);
        send_byte(ra, acks[1]);
        send_byte(d, acks[2]);
        bus_stop();
    endtask

    task automatic read_txn(input logic [7:0] ra, output logic [2:0] acks,
                            output logic [7:0] v, output logic rel);
        logic r;
        bus_start();
        send_byte({DEV, 1'b0}, acks[0]);
        send_byte(ra, acks[1]);
        bus_start();
        send_byte({DEV, 1'b1}, acks[2]);
        for (int i = 0; i < 8; i++) begin xfer_bit(1'b1, r); v = {v[6:0], r}; end
        xfer_bit(1'b1, r);
        rel = r;
        wait_q(2*Q);
        rel = rel && !sda_oe;
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] acks;
        logic [7:0] v;
        logic rel, r;
        int w0, r0;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        wait_q(4);
        check(!sda_oe && !reg_wr_en && !reg_rd_en, "R1 reset outputs",
              {sda_oe, reg_wr_en, reg_rd_en}, 0);
        rst_n = 1;
        wait_q(4);
        check(!sda_oe && !reg_wr_en && !reg_rd_en, "R1 after reset release",
              {sda_oe, reg_wr_en, reg_rd_en}, 0);

        // R2 / R3 sweep over all device addresses
        for (int a = 0; a < 128; a++) begin
            w0 = wr_cnt; r0 = rd_cnt;
            write_txn(7'(a), 8'(a), 8'(a*3 + 1), acks);
            if (7'(a) == DEV) begin
                check(acks == 3'b111, "R2 acks on match", acks, 7);
                check(wr_cnt == w0 + 1 && wr_a == 8'(a) && wr_d == 8'(a*3 + 1),
                      "R2 write strobe", {wr_a, wr_d}, {8'(a), 8'(a*3 + 1)});
            end else begin
                check(acks == 3'b000 && wr_cnt == w0 && rd_cnt == r0,
                      "R3 ignored address", {acks, 8'(wr_cnt - w0)}, 0);
            end
        end

        // R2 / R4 write then read back several patterns
        for (int k = 0; k < 12; k++) begin
            logic [7:0] ra, d;
            ra = 8'(k * 23 + 5);
            d  = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(k * 37 + 9);
            write_txn(DEV, ra, d, acks);
            check(acks == 3'b111 && mem[ra] == d, "R2 pattern write", mem[ra], d);
            r0 = rd_cnt;
            read_txn(ra, acks, v, rel);
            check(acks == 3'b111, "R4 read acks", acks, 7);
            check(rd_cnt == r0 + 1 && rd_a == ra, "R4 read request address", rd_a, ra);
            check(v == d, "R4 read data", v, d);
            check(rel, "R5 line released after read byte", rel, 1);
        end
        // read of untouched register holds its initial value
        read_txn(8'hFE, acks, v, rel);
        check(v == (8'hFE ^ 8'h5A), "R4 read initial value", v, 8'hFE ^ 8'h5A);

        // R7 start in the middle of a byte
        w0 = wr_cnt;
        bus_start();
        for (int i = 0; i < 4; i++) xfer_bit(1'(i & 1), r);
        bus_start();
        send_byte({DEV, 1'b0}, acks[0]);
        for (int i = 0; i < 3; i++) xfer_bit(1'b1, r);
        bus_start();
        send_byte({DEV, 1'b0}, acks[0]);
        send_byte(8'h33, acks[1]);
        send_byte(8'hC4, acks[2]);
        bus_stop();
        check(acks == 3'b111 && wr_cnt == w0 + 1 && wr_a == 8'h33 && wr_d == 8'hC4,
              "R7 restart mid-byte", {wr_a, wr_d}, 16'h33C4);

        // R8 read direction after stop is refused
        r0 = rd_cnt;
        bus_start();
        send_byte({DEV, 1'b1}, acks[0]);
        for (int i = 0; i < 9; i++) xfer_bit(1'b1, r);
        bus_stop();
        check(!acks[0] && rd_cnt == r0, "R8 read after stop refused", {acks[0], 8'(rd_cnt - r0)}, 0);

        check(oe_err == 0, "R6 drive changes only with clock low", oe_err, 0);
        check(width_err == 0 && excl_err == 0, "R9 strobe width and exclusion",
              width_err + excl_err, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule